// File: doc/BRIEF.md
# Ring-Buffer Byte DMA Channel for a Serial Port

This block is one DMA channel that carries bytes between a serial port and a circular buffer in memory. A strap input selects the direction. In the transmit direction, software fills the ring, moves the write pointer forward, and the channel reads bytes out of memory into a byte stream toward the serial port. In the receive direction, the channel takes bytes from the serial port's stream and writes them into the ring. Software then consumes them by moving the read pointer.

Each pointer is a 16-bit byte offset with a wrap flag above it. Because of the wrap flag, a full ring and an empty ring read as different states. The channel derives two counts from the pointers: the occupied byte count and the free space. It raises a threshold interrupt from one of these counts, depending on direction. It also supports three control requests through its register port: a flush that clears itself, a stop that drains before it takes effect, and a warm reset. Registers are 32 bits wide and sit at byte offsets on an 8-bit address. Writes take effect at the clock edge. Reads are combinational. The memory side is a byte port: write data is captured on the clock edge, and read data comes back in the same cycle.

Top module: `uart_ring_dma`

## Requirements
- R1: After reset, every register reads 0, irq_o is low, and neither tx_valid_o nor rx_ready_o is asserted.
- R2: A pointer holds its offset in bits 15:0 and its wrap flag in bit 16. When the hardware advances a pointer and the incremented offset equals the length register (0x30), the offset becomes 0 and the wrap flag inverts.
- R3: The valid-size register (0x3C) returns the write offset minus the read offset, with the length added when the two wrap flags differ. The left-size register (0x40) returns the length minus the valid size.
- R4: With dir_rx_i low and the enable register (0x08, bit 0) set, the channel offers one byte while valid size is non-zero. The byte is read from memory at the address of the read pointer (0x2C). Each accepted byte advances the read pointer, and an offered byte stays offered until it is accepted.
- R5: With dir_rx_i high and enable set, rx_ready_o is high while left size is non-zero. Each accepted byte is written to memory at the address of the write pointer (0x28), and the write pointer advances. A full ring drops rx_ready_o.
- R6: In receive, when the interrupt-enable register (0x04) is non-zero and valid size is at or above the threshold (0x24), the flag register (0x00) becomes 3 and irq_o goes high. Any write to 0x00 clears the flag.
- R7: In transmit, when interrupt enable is non-zero and left size is at or above the threshold, the flag becomes 1 and the hardware clears interrupt enable to 0.
- R8: Writing 1 to bit 0 of the flush register (0x14) sets it. The bit reads back 0 once transmit valid size is 0, or the channel is disabled, or the direction is receive.
- R9: Writing 1 to the stop register (0x10) blocks new receive bytes. Enable reads 0 once no transmit byte is left offered but unaccepted. Stop keeps reading 1 until software writes 0.
- R10: Writing 1 to bit 0 of the reset register (0x0C) clears enable, stop, flush and both pointers.
- R11: mem_addr_o equals {bit 0 of register 0x54, base register 0x1C} plus the offset of the active pointer: the read pointer in transmit, the write pointer in receive.
- R12: The debug register (0x50) reads 3 while stop is set, otherwise 2 while flush is set, otherwise 1 while enabled, otherwise 0.
- R13: A software write to a pointer register reads back, and is reflected in valid size, at the next read after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rx_i | input | 1 | Direction strap: 1 receive, 0 transmit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Threshold interrupt |
| mem_addr_o | output | BASE_W+1 | Memory byte address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, same cycle |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Serial port takes transmit byte |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_ready_o | output | 1 | Channel takes receive byte |
| rx_data_i | input | 8 | Receive byte |

## Verification
The bench builds the channel with its default parameters: a 16-bit offset and a 32-bit base. Ring lengths are programmed at run time (4, 8, 16 and 100 bytes), so a few handshakes are enough to reach offset wrap-around, full rings and empty rings. A 33-bit address is produced by combining the high-address bit with a 32-bit base. The occupancy table uses hand-set pointer pairs to cover wrap-flag combinations that live traffic would take thousands of cycles to reach.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam logic [7:0] A_FLAG   = 8'h00;
  localparam logic [7:0] A_IEN    = 8'h04;
  localparam logic [7:0] A_EN     = 8'h08;
  localparam logic [7:0] A_RST    = 8'h0C;
  localparam logic [7:0] A_STOP   = 8'h10;
  localparam logic [7:0] A_FLUSH  = 8'h14;
  localparam logic [7:0] A_BASE   = 8'h1C;
  localparam logic [7:0] A_THRE   = 8'h24;
  localparam logic [7:0] A_WPT    = 8'h28;
  localparam logic [7:0] A_RPT    = 8'h2C;
  localparam logic [7:0] A_LEN    = 8'h30;
  localparam logic [7:0] A_VALID  = 8'h3C;
  localparam logic [7:0] A_LEFT   = 8'h40;
  localparam logic [7:0] A_DBG    = 8'h50;
  localparam logic [7:0] A_HIADDR = 8'h54;

  localparam logic [1:0] FLAG_RX = 2'b11;
  localparam logic [1:0] FLAG_TX = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_STOP  = 2'd3
  } chan_state_e;
endpackage

// File: rtl/uart_dma_cfg.sv
module uart_dma_cfg #(
  parameter int OFF_W  = 16,
  parameter int BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_base_i,
  input  logic              wr_len_i,
  input  logic              wr_thre_i,
  input  logic              wr_hi_i,
  input  logic [31:0]       wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [OFF_W-1:0]  len_o,
  output logic [OFF_W-1:0]  thre_o,
  output logic              hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      len_o  <= '0;
      thre_o <= '0;
      hi_o   <= 1'b0;
    end else begin
      if (wr_base_i) base_o <= wdata_i[BASE_W-1:0];
      if (wr_len_i)  len_o  <= wdata_i[OFF_W-1:0];
      if (wr_thre_i) thre_o <= wdata_i[OFF_W-1:0];
      if (wr_hi_i)   hi_o   <= wdata_i[0];
    end
  end
endmodule

// File: rtl/uart_dma_ptrs.sv
module uart_dma_ptrs #(
  parameter int OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_rx_i,
  input  logic             clr_i,
  input  logic [1:0]       wr_i,      // [0] write ptr, [1] read ptr
  input  logic [OFF_W:0]   wdata_i,
  input  logic             adv_i,
  input  logic [OFF_W-1:0] len_i,
  output logic [OFF_W:0]   wpt_o,
  output logic [OFF_W:0]   rpt_o,
  output logic [OFF_W-1:0] valid_o,
  output logic [OFF_W-1:0] left_o
);
  localparam int PW = OFF_W + 1;

  function automatic logic [OFF_W:0] bump(input logic [OFF_W:0] p, input logic [OFF_W-1:0] l);
    logic [OFF_W:0] inc;
    inc = {1'b0, p[OFF_W-1:0]} + PW'(1);
    if (inc == {1'b0, l}) bump = {~p[OFF_W], {OFF_W{1'b0}}};
    else                  bump = {p[OFF_W], inc[OFF_W-1:0]};
  endfunction

  logic [1:0][OFF_W:0] ptr_all;

  // pointer 0 is hardware-owned in receive, pointer 1 in transmit
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    logic           hw_own;
    logic [OFF_W:0] q;
    assign hw_own = (g == 0) ? dir_rx_i : !dir_rx_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               q <= '0;
      else if (clr_i)            q <= '0;
      else if (wr_i[g])          q <= wdata_i;
      else if (adv_i && hw_own)  q <= bump(q, len_i);
    end
    assign ptr_all[g] = q;
  end

  assign wpt_o = ptr_all[0];
  assign rpt_o = ptr_all[1];

  logic [OFF_W-1:0] diff;
  assign diff    = wpt_o[OFF_W-1:0] - rpt_o[OFF_W-1:0];
  assign valid_o = (wpt_o[OFF_W] ^ rpt_o[OFF_W]) ? diff + len_i : diff;
  assign left_o  = len_i - valid_o;
endmodule

// File: rtl/uart_dma_ctrl.sv
module uart_dma_ctrl
  import uart_dma_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_rx_i,
  input  logic             clr_i,
  input  logic             wr_flag_i,
  input  logic             wr_ien_i,
  input  logic             wr_en_i,
  input  logic             wr_stop_i,
  input  logic             wr_flush_i,
  input  logic [1:0]       wbits_i,
  input  logic [OFF_W-1:0] valid_i,
  input  logic [OFF_W-1:0] left_i,
  input  logic [OFF_W-1:0] thre_i,
  input  logic             tx_busy_i,
  input  logic             tx_ready_i,
  output logic             en_o,
  output logic [1:0]       ien_o,
  output logic [1:0]       flag_o,
  output logic             stop_o,
  output logic             flush_o,
  output chan_state_e      state_o
);
  logic hit_rx, hit_tx, drained, flush_done;

  assign hit_rx     = dir_rx_i  && (ien_o != 2'b00) && (valid_i >= thre_i);
  assign hit_tx     = !dir_rx_i && (ien_o != 2'b00) && (left_i  >= thre_i);
  // no transmit byte left hanging on the stream
  assign drained    = dir_rx_i || !tx_busy_i || tx_ready_i;
  assign flush_done = dir_rx_i || (valid_i == '0) || !en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      ien_o   <= 2'b00;
      flag_o  <= 2'b00;
      stop_o  <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      if (clr_i)                           en_o <= 1'b0;
      else if (wr_en_i)                    en_o <= wbits_i[0];
      else if (stop_o && en_o && drained)  en_o <= 1'b0;

      if (wr_ien_i)    ien_o <= wbits_i;
      else if (hit_tx) ien_o <= 2'b00;

      if (wr_flag_i)   flag_o <= 2'b00;
      else if (hit_rx) flag_o <= FLAG_RX;
      else if (hit_tx) flag_o <= FLAG_TX;

      if (clr_i)          stop_o <= 1'b0;
      else if (wr_stop_i) stop_o <= wbits_i[0];

      if (clr_i)                      flush_o <= 1'b0;
      else if (wr_flush_i)            flush_o <= wbits_i[0];
      else if (flush_o && flush_done) flush_o <= 1'b0;
    end
  end

  always_comb begin
    if (stop_o)       state_o = ST_STOP;
    else if (flush_o) state_o = ST_FLUSH;
    else if (en_o)    state_o = ST_RUN;
    else              state_o = ST_IDLE;
  end
endmodule

// File: rtl/uart_ring_dma.sv
module uart_ring_dma
  import uart_dma_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int BASE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic [BASE_W:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i
);
  localparam int AW = BASE_W + 1;

  logic wr_flag, wr_ien, wr_en, wr_rst, wr_stop, wr_flush;
  logic wr_base, wr_thre, wr_wpt, wr_rpt, wr_len, wr_hi, clr;

  assign wr_flag  = reg_we_i && (reg_addr_i == A_FLAG);
  assign wr_ien   = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_en    = reg_we_i && (reg_addr_i == A_EN);
  assign wr_rst   = reg_we_i && (reg_addr_i == A_RST);
  assign wr_stop  = reg_we_i && (reg_addr_i == A_STOP);
  assign wr_flush = reg_we_i && (reg_addr_i == A_FLUSH);
  assign wr_base  = reg_we_i && (reg_addr_i == A_BASE);
  assign wr_thre  = reg_we_i && (reg_addr_i == A_THRE);
  assign wr_wpt   = reg_we_i && (reg_addr_i == A_WPT);
  assign wr_rpt   = reg_we_i && (reg_addr_i == A_RPT);
  assign wr_len   = reg_we_i && (reg_addr_i == A_LEN);
  assign wr_hi    = reg_we_i && (reg_addr_i == A_HIADDR);
  assign clr      = wr_rst && reg_wdata_i[0];

  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  len_q, thre_q;
  logic              hi_q;

  uart_dma_cfg #(.OFF_W(OFF_W), .BASE_W(BASE_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_base_i (wr_base),
    .wr_len_i  (wr_len),
    .wr_thre_i (wr_thre),
    .wr_hi_i   (wr_hi),
    .wdata_i   (reg_wdata_i),
    .base_o    (base_q),
    .len_o     (len_q),
    .thre_o    (thre_q),
    .hi_o      (hi_q)
  );

  logic [OFF_W:0]   wpt_q, rpt_q;
  logic [OFF_W-1:0] valid_sz, left_sz;
  logic             tx_fire, rx_fire;

  uart_dma_ptrs #(.OFF_W(OFF_W)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_rx_i (dir_rx_i),
    .clr_i    (clr),
    .wr_i     ({wr_rpt, wr_wpt}),
    .wdata_i  (reg_wdata_i[OFF_W:0]),
    .adv_i    (tx_fire || rx_fire),
    .len_i    (len_q),
    .wpt_o    (wpt_q),
    .rpt_o    (rpt_q),
    .valid_o  (valid_sz),
    .left_o   (left_sz)
  );

  logic        en_q, stop_q, flush_q;
  logic [1:0]  ien_q, flag_q;
  chan_state_e state;

  uart_dma_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_rx_i   (dir_rx_i),
    .clr_i      (clr),
    .wr_flag_i  (wr_flag),
    .wr_ien_i   (wr_ien),
    .wr_en_i    (wr_en),
    .wr_stop_i  (wr_stop),
    .wr_flush_i (wr_flush),
    .wbits_i    (reg_wdata_i[1:0]),
    .valid_i    (valid_sz),
    .left_i     (left_sz),
    .thre_i     (thre_q),
    .tx_busy_i  (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .en_o       (en_q),
    .ien_o      (ien_q),
    .flag_o     (flag_q),
    .stop_o     (stop_q),
    .flush_o    (flush_q),
    .state_o    (state)
  );

  // byte datapath
  logic [OFF_W-1:0] act_off;
  assign act_off     = dir_rx_i ? wpt_q[OFF_W-1:0] : rpt_q[OFF_W-1:0];
  assign mem_addr_o  = {hi_q, base_q} + AW'(act_off);

  assign tx_valid_o  = !dir_rx_i && en_q && (valid_sz != '0);
  assign tx_data_o   = mem_rdata_i;
  assign mem_re_o    = tx_valid_o;
  assign tx_fire     = tx_valid_o && tx_ready_i;

  assign rx_ready_o  = dir_rx_i && en_q && !stop_q && (left_sz != '0);
  assign rx_fire     = rx_ready_o && rx_valid_i;
  assign mem_we_o    = rx_fire;
  assign mem_wdata_o = rx_data_i;

  assign irq_o = |flag_q;

  always_comb begin
    case (reg_addr_i)
      A_FLAG:   reg_rdata_o = 32'(flag_q);
      A_IEN:    reg_rdata_o = 32'(ien_q);
      A_EN:     reg_rdata_o = 32'(en_q);
      A_STOP:   reg_rdata_o = 32'(stop_q);
      A_FLUSH:  reg_rdata_o = 32'(flush_q);
      A_BASE:   reg_rdata_o = 32'(base_q);
      A_THRE:   reg_rdata_o = 32'(thre_q);
      A_WPT:    reg_rdata_o = 32'(wpt_q);
      A_RPT:    reg_rdata_o = 32'(rpt_q);
      A_LEN:    reg_rdata_o = 32'(len_q);
      A_VALID:  reg_rdata_o = 32'(valid_sz);
      A_LEFT:   reg_rdata_o = 32'(left_sz);
      A_DBG:    reg_rdata_o = 32'(state);
      A_HIADDR: reg_rdata_o = 32'(hi_q);
      default:  reg_rdata_o = 32'h0;
    endcase
  end
endmodule

// File: rtl/uart_ring_dma_chk.sv
module uart_ring_dma_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_rx_i,
  input logic             reg_we_i,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             rx_valid_i,
  input logic             rx_ready_o,
  input logic             en_q,
  input logic             stop_q,
  input logic [1:0]       ien_q,
  input logic [1:0]       flag_q,
  input logic [OFF_W:0]   wpt_q,
  input logic [OFF_W:0]   rpt_q,
  input logic [OFF_W-1:0] valid_sz,
  input logic [OFF_W-1:0] left_sz,
  input logic [OFF_W-1:0] len_q,
  input logic [OFF_W-1:0] thre_q
);
  assert_tx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !reg_we_i |=> tx_valid_o && $stable(rpt_q));

  assert_rx_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> valid_sz < len_q);

  assert_rx_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o && rx_valid_i && !reg_we_i |=> wpt_q != $past(wpt_q));

  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 8'h00 |=> flag_q == 2'b00);

  assert_tx_ien_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_rx_i && ien_q != 2'b00 && left_sz >= thre_q && !reg_we_i |=> ien_q == 2'b00);

  assert_stop_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> !rx_ready_o);

  assert_warm_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 8'h0C && reg_wdata_i[0] |=> !en_q && wpt_q == '0 && rpt_q == '0);

  assert_left_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_sz == OFF_W'(len_q - valid_sz));
endmodule

bind uart_ring_dma uart_ring_dma_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dir_rx_i    (dir_rx_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .rx_valid_i  (rx_valid_i),
  .rx_ready_o  (rx_ready_o),
  .en_q        (en_q),
  .stop_q      (stop_q),
  .ien_q       (ien_q),
  .flag_q      (flag_q),
  .wpt_q       (wpt_q),
  .rpt_q       (rpt_q),
  .valid_sz    (valid_sz),
  .left_sz     (left_sz),
  .len_q       (len_q),
  .thre_q      (thre_q)
);

// File: tb/sim_uart_ring_dma.sv
`timescale 1ns/1ps
module sim_uart_ring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rx = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [32:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        tx_valid, tx_data_unused;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h0;

  int n_run = 0;
  int n_fail = 0;
  int cap_n = 0;
  logic [7:0] cap [0:63];
  logic [7:0] ram [0:511];

  always #5 clk = ~clk;

  uart_ring_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_rx_i(dir_rx),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data)
  );

  assign tx_data_unused = mem_re;
  // transmit source memory: byte = low address byte xor 0x5A
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[8:0]] <= mem_wdata;
    if (tx_valid && tx_ready) begin
      cap[cap_n[5:0]] <= tx_data;
      cap_n <= cap_n + 1;
    end
  end

  typedef struct packed {
    logic [15:0] len;
    logic [16:0] w;
    logic [16:0] r;
    logic [15:0] v;
    logic [15:0] l;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'd8,   17'h00005, 17'h00002, 16'd3,  16'd5},
    '{16'd8,   17'h10002, 17'h00006, 16'd4,  16'd4},
    '{16'd8,   17'h10004, 17'h00004, 16'd8,  16'd0},
    '{16'd8,   17'h10004, 17'h10004, 16'd0,  16'd8},
    '{16'd16,  17'h00003, 17'h1000D, 16'd6,  16'd10},
    '{16'd100, 17'h00063, 17'h00000, 16'd99, 16'd1}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic exp_rdy, input string tag);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #1;
    chk(tag, 64'(rx_ready), 64'(exp_rdy));
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base_n;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    rdchk("R1 flag", 8'h00, 0);
    rdchk("R1 ien", 8'h04, 0);
    rdchk("R1 en", 8'h08, 0);
    rdchk("R1 wpt", 8'h28, 0);
    rdchk("R1 dbg", 8'h50, 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 tx_valid", 64'(tx_valid), 0);
    chk("R1 rx_ready", 64'(rx_ready), 0);

    // R3 occupancy table, R13 pointer readback
    for (int i = 0; i < 6; i++) begin
      wr(8'h30, 32'(VEC[i].len));
      wr(8'h28, 32'(VEC[i].w));
      wr(8'h2C, 32'(VEC[i].r));
      rdchk("R13 wpt readback", 8'h28, 32'(VEC[i].w));
      rdchk("R3 valid size", 8'h3C, 32'(VEC[i].v));
      rdchk("R3 left size", 8'h40, 32'(VEC[i].l));
    end

    // R4 transmit three bytes
    wr(8'h30, 8);
    wr(8'h1C, 32'h100);
    wr(8'h2C, 0);
    wr(8'h28, 3);
    tx_ready = 1'b1;
    base_n = cap_n;
    wr(8'h08, 1);
    rdchk("R12 dbg active", 8'h50, 1);
    cycles(6);
    chk("R4 byte count", 64'(cap_n - base_n), 3);
    for (int k = 0; k < 3; k++) chk("R4 byte data", 64'(cap[(base_n + k) % 64]), 64'(8'(k) ^ 8'h5A));
    rdchk("R4 rpt", 8'h2C, 3);
    chk("R4 empty no offer", 64'(tx_valid), 0);

    // R2 transmit across the wrap
    wr(8'h08, 0);
    wr(8'h2C, 6);
    wr(8'h28, 32'h10001);
    base_n = cap_n;
    wr(8'h08, 1);
    cycles(6);
    chk("R2 wrap count", 64'(cap_n - base_n), 3);
    chk("R2 wrap byte6", 64'(cap[(base_n + 0) % 64]), 64'(8'h06 ^ 8'h5A));
    chk("R2 wrap byte0", 64'(cap[(base_n + 2) % 64]), 64'(8'h00 ^ 8'h5A));
    rdchk("R2 rpt wrapped", 8'h2C, 32'h10001);

    // R7 transmit threshold interrupt
    wr(8'h24, 4);
    wr(8'h04, 1);
    cycles(2);
    rdchk("R7 ien self-clear", 8'h04, 0);
    rdchk("R7 flag", 8'h00, 1);
    chk("R7 irq", 64'(irq), 1);
    wr(8'h00, 0);
    rdchk("R6 flag cleared", 8'h00, 0);
    chk("R6 irq low", 64'(irq), 0);

    // R8 flush handshake, R12 states
    wr(8'h08, 0);
    tx_ready = 1'b0;
    wr(8'h2C, 0);
    wr(8'h28, 2);
    wr(8'h08, 1);
    wr(8'h14, 1);
    rdchk("R8 flush pending", 8'h14, 1);
    rdchk("R12 dbg flushing", 8'h50, 2);
    @(negedge clk); tx_ready = 1'b1;
    cycles(5);
    rdchk("R8 flush done", 8'h14, 0);
    rdchk("R12 dbg back to active", 8'h50, 1);

    // R9 transmit stop drains the offered byte
    wr(8'h08, 0);
    tx_ready = 1'b0;
    wr(8'h28, 4);
    wr(8'h08, 1);
    wr(8'h10, 1);
    cycles(2);
    rdchk("R9 en held while pending", 8'h08, 1);
    chk("R9 byte still offered", 64'(tx_valid), 1);
    rdchk("R12 dbg stopping", 8'h50, 3);
    @(negedge clk); tx_ready = 1'b1;
    cycles(3);
    rdchk("R9 en drained", 8'h08, 0);
    rdchk("R9 one byte moved", 8'h2C, 3);
    rdchk("R9 stop sticky", 8'h10, 1);
    tx_ready = 1'b0;
    wr(8'h10, 0);

    // R10 warm reset
    wr(8'h08, 1);
    wr(8'h0C, 1);
    rdchk("R10 en", 8'h08, 0);
    rdchk("R10 wpt", 8'h28, 0);
    rdchk("R10 rpt", 8'h2C, 0);

    // R11 address composition
    wr(8'h30, 32'h40);
    wr(8'h54, 1);
    wr(8'h1C, 32'h1000);
    wr(8'h2C, 32'h20);
    #1;
    chk("R11 mem addr", 64'(mem_addr), 64'h1_0000_1020);
    wr(8'h54, 0);

    // R5 receive fills ring then stalls
    wr(8'h0C, 1);
    dir_rx = 1'b1;
    wr(8'h30, 4);
    wr(8'h1C, 32'h80);
    wr(8'h08, 1);
    for (int k = 0; k < 4; k++) send_rx(8'hA0 + 8'(k), 1'b1, "R5 accept");
    send_rx(8'hA4, 1'b0, "R5 full stall");
    rdchk("R5 valid full", 8'h3C, 4);
    rdchk("R5 left zero", 8'h40, 0);
    rdchk("R2 rx wpt wrapped", 8'h28, 32'h10000);
    for (int k = 0; k < 4; k++) chk("R5 ram data", 64'(ram[9'h80 + 9'(k)]), 64'(8'hA0 + 8'(k)));

    // R6 receive threshold interrupt
    wr(8'h24, 3);
    wr(8'h04, 3);
    cycles(2);
    rdchk("R6 rx flag", 8'h00, 3);
    chk("R6 irq", 64'(irq), 1);
    rdchk("R6 ien kept", 8'h04, 3);

    // R13 software consumes
    wr(8'h2C, 32'h10000);
    rdchk("R13 rpt", 8'h2C, 32'h10000);
    rdchk("R13 valid empty", 8'h3C, 0);
    chk("R13 room again", 64'(rx_ready), 1);

    // R9 receive stop
    wr(8'h10, 1);
    #1;
    chk("R9 rx blocked", 64'(rx_ready), 0);
    cycles(1);
    rdchk("R9 rx en off", 8'h08, 0);
    rdchk("R12 dbg stop rx", 8'h50, 3);
    wr(8'h10, 0);
    rdchk("R12 dbg idle", 8'h50, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule